// File: doc/BRIEF.md
# Four-Step-Search Shift Direction Sequencer

This block is the control core that steers a reference-pixel shift array during a four-step motion search. The array holds the candidate block under evaluation and can move its contents by one pixel up, down, left or right in a single cycle. When one search step finishes, the block receives two inputs. The first is the corner of the 3×3 pattern where the array's walk ended. The second is the best-matching position in that pattern. From these it emits one shift direction per cycle. The walk starts at that corner, crosses already-evaluated positions where it has to, and passes through every candidate that the new pattern adds. Every move lands on a neighbouring position, so the array always reuses the pixels it already holds. The same direction stream drives the array's mode and the search-window address generator.

The walk for each pair of corner and best match is held in a table. The table is filled at elaboration from the search geometry and indexed by a move counter. Each table entry also says whether the move lands on a candidate that the new pattern adds, so the downstream cost logic knows which cycles to score. When the walk ends, the block reports the corner of the new pattern where the array now sits, and that value feeds the next step. A best match at the centre starts no walk; it raises a refinement request instead.

Top module: `fss_dir_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `busy`, `shift_vld`, `cand_vld`, `step_done` and `refine_req` are low and `ep_out` is 0.
- R2: Encodings: corners are 0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right. Pattern positions are numbered row-major 0..8 from top-left, with 4 the centre. Directions are 0 up, 1 down, 2 left, 3 right. Coordinates grow rightward and downward, and one pattern step equals one pixel.
- R3: A `step_go` sampled while idle, with a position other than 4 and not above 8, starts a walk. The first move appears in the next cycle, with one move per cycle and no gaps. `step_done` is high for exactly one cycle, directly after the last move. `busy` is high from the first move through `step_done`.
- R4: `cand_vld` is high exactly on the moves that land on a position inside the new pattern but outside the previous one, and each such position is flagged once. An edge best match adds 3 such positions and a diagonal best match adds 5.
- R5: The walk first goes to the nearer end of the strip of added positions, then follows the strip to its other end; a diagonal strip turns at its outer corner. Between waypoints, all horizontal moves come before all vertical ones. For a diagonal best match, a tie in Manhattan distance picks the end that lies on the strip's horizontal row. Length = distance to that end + 2 (edge) or + 4 (diagonal).
- R6: With end corner bottom-left and best match right (position 5), the walk is right, right, right, up, up, and it ends on the top-right corner.
- R7: During `step_done`, `ep_out` gives the corner of the new pattern where the walk ended. It keeps that value until the next `step_done`.
- R8: A start with position 4 produces no move and leaves `busy` low. Instead it pulses `refine_req` high for one cycle, in the cycle after the request.
- R9: A `step_go` that arrives while `busy` is high, or that carries a position above 8, has no effect on the outputs.
- R10: No walk exceeds 8 moves. End corner bottom-left with best match top-right takes exactly 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_go | input | 1 | Start request for one search step |
| ep_in | input | 2 | Corner where the previous walk ended |
| mp_in | input | 4 | Best-matching position of the previous step |
| busy | output | 1 | A walk is in progress |
| shift_vld | output | 1 | A shift is issued this cycle |
| shift_dir | output | 2 | Direction of the shift |
| cand_vld | output | 1 | The shift lands on a newly added candidate |
| step_done | output | 1 | The walk for this step is complete |
| ep_out | output | 2 | Corner reached by the last completed walk |
| refine_req | output | 1 | Centre best match; refinement requested |

## Verification
The hardest cases to reach are the diagonal best matches where both ends of the L-shaped strip are the same distance away. A poor tie rule there would step onto a new candidate early and flag it twice. The other hard case is a start request that arrives in the middle of a walk. The stimulus sweeps all 32 pairs of corner and best match and checks every move against a behavioural walk model. It repeats one pair while pulsing a conflicting request during the walk. It also chains steps by feeding `ep_out` back as the next end corner, so that sequences running back to back are covered.

// File: rtl/fss_pkg.sv
package fss_pkg;

    localparam int MAX_MOVES = 8;
    localparam int ENTRY_W   = 4;
    localparam int SEQ_W     = MAX_MOVES * ENTRY_W;
    localparam int ROW_BITS  = SEQ_W + 2;
    localparam int NUM_EP    = 4;
    localparam int NUM_MP    = 8;
    localparam int ROWS      = NUM_EP * NUM_MP;
    localparam int ROW_W     = $clog2(ROWS);
    localparam int CNT_W     = $clog2(MAX_MOVES + 1);
    localparam int MP_CENTER = 4;
    localparam int MP_LAST   = 8;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_DOWN  = 2'd1,
        DIR_LEFT  = 2'd2,
        DIR_RIGHT = 2'd3
    } dir_e;

    typedef struct packed {
        logic vld;
        logic cand;
        dir_e dir;
    } move_t;

    typedef struct packed {
        logic             busy;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       ep_last;
        logic             refine;
    } ctl_t;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int mdist(input int ax, input int ay, input int bx, input int by);
        return iabs(ax - bx) + iabs(ay - by);
    endfunction

    // inside the pattern centred at (cx,cy) and outside the old one at (0,0)
    function automatic logic is_fresh(input int x, input int y, input int cx, input int cy);
        return (iabs(x - cx) <= 1) && (iabs(y - cy) <= 1) &&
               ((iabs(x) > 1) || (iabs(y) > 1));
    endfunction

    // Builds one table row: moves in the low SEQ_W bits, final corner on top.
    function automatic logic [ROW_BITS-1:0] build_row(input int ep, input int mpi);
        logic [ROW_BITS-1:0] res;
        int pos, cx, cy, x, y, n, nwp, da, db;
        int w0x, w0y, w1x, w1y, w2x, w2y, tx, ty;
        dir_e d;
        res = '0;
        pos = (mpi < MP_CENTER) ? mpi : mpi + 1;
        cx  = (pos % 3) - 1;
        cy  = (pos / 3) - 1;
        x   = ((ep % 2) == 1) ? 1 : -1;
        y   = ((ep / 2) == 1) ? 1 : -1;
        w2x = 0;
        w2y = 0;
        if (cx == 0 || cy == 0) begin
            nwp = 2;
            if (cx != 0) begin
                w0x = 2 * cx; w0y = -1; w1x = 2 * cx; w1y = 1;
            end else begin
                w0x = -1; w0y = 2 * cy; w1x = 1; w1y = 2 * cy;
            end
            if (mdist(x, y, w1x, w1y) < mdist(x, y, w0x, w0y)) begin
                tx = w0x; ty = w0y;
                w0x = w1x; w0y = w1y;
                w1x = tx;  w1y = ty;
            end
        end else begin
            nwp = 3;
            w1x = 2 * cx; w1y = 2 * cy;
            da  = mdist(x, y, 2 * cx, 0);
            db  = mdist(x, y, 0, 2 * cy);
            if (da < db) begin
                w0x = 2 * cx; w0y = 0; w2x = 0; w2y = 2 * cy;
            end else begin
                w0x = 0; w0y = 2 * cy; w2x = 2 * cx; w2y = 0;
            end
        end
        n = 0;
        for (int w = 0; w < 3; w++) begin
            if (w < nwp) begin
                tx = (w == 0) ? w0x : ((w == 1) ? w1x : w2x);
                ty = (w == 0) ? w0y : ((w == 1) ? w1y : w2y);
                for (int s = 0; s < 4; s++) begin
                    if (x != tx) begin
                        d = (x < tx) ? DIR_RIGHT : DIR_LEFT;
                        x = (x < tx) ? x + 1 : x - 1;
                        res[n*ENTRY_W +: ENTRY_W] = {1'b1, is_fresh(x, y, cx, cy), d};
                        n = n + 1;
                    end
                end
                for (int s = 0; s < 4; s++) begin
                    if (y != ty) begin
                        d = (y < ty) ? DIR_DOWN : DIR_UP;
                        y = (y < ty) ? y + 1 : y - 1;
                        res[n*ENTRY_W +: ENTRY_W] = {1'b1, is_fresh(x, y, cx, cy), d};
                        n = n + 1;
                    end
                end
            end
        end
        res[ROW_BITS-1] = ((y - cy) > 0);
        res[ROW_BITS-2] = ((x - cx) > 0);
        return res;
    endfunction

endpackage

// File: rtl/fss_mp_decode.sv
module fss_mp_decode
    import fss_pkg::*;
(
    input  logic [3:0] mp_i,
    output logic       ok_o,
    output logic       center_o,
    output logic [2:0] idx_o
);
    always_comb begin
        ok_o     = 1'b1;
        center_o = 1'b0;
        idx_o    = 3'd0;
        case (mp_i)
            4'd0: idx_o = 3'd0;
            4'd1: idx_o = 3'd1;
            4'd2: idx_o = 3'd2;
            4'd3: idx_o = 3'd3;
            4'd4: center_o = 1'b1;
            4'd5: idx_o = 3'd4;
            4'd6: idx_o = 3'd5;
            4'd7: idx_o = 3'd6;
            4'd8: idx_o = 3'd7;
            default: ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fss_walk_rom.sv
module fss_walk_rom
    import fss_pkg::*;
(
    input  logic [ROW_W-1:0] row_i,
    input  logic [CNT_W-1:0] cnt_i,
    output move_t            ent_o,
    output logic [1:0]       corner_o
);
    logic [SEQ_W-1:0] seq_tab    [ROWS];
    logic [1:0]       corner_tab [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam logic [ROW_BITS-1:0] ROW_VAL = build_row(r / NUM_MP, r % NUM_MP);
        assign seq_tab[r]    = ROW_VAL[SEQ_W-1:0];
        assign corner_tab[r] = ROW_VAL[ROW_BITS-1:SEQ_W];
    end

    always_comb begin
        ent_o = '0;
        for (int k = 0; k < MAX_MOVES; k++) begin
            if (cnt_i == CNT_W'(k)) begin
                ent_o = move_t'(seq_tab[row_i][k*ENTRY_W +: ENTRY_W]);
            end
        end
        corner_o = corner_tab[row_i];
    end
endmodule

// File: rtl/fss_step_ctl.sv
module fss_step_ctl
    import fss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_go,
    input  logic [1:0]       ep_in,
    input  logic             mp_ok,
    input  logic             mp_center,
    input  logic [2:0]       mp_idx,
    input  move_t            ent,
    input  logic [1:0]       ent_corner,
    output logic [ROW_W-1:0] row_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busy,
    output logic             shift_vld,
    output logic [1:0]       shift_dir,
    output logic             cand_vld,
    output logic             step_done,
    output logic [1:0]       ep_out,
    output logic             refine_req
);
    ctl_t st_d, st_q;
    logic walk_end;

    assign walk_end = st_q.busy && !ent.vld;

    always_comb begin
        st_d        = st_q;
        st_d.refine = 1'b0;
        if (!st_q.busy) begin
            if (step_go && mp_ok) begin
                if (mp_center) begin
                    st_d.refine = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.row  = {ep_in, mp_idx};
                    st_d.cnt  = '0;
                end
            end
        end else if (walk_end) begin
            st_d.busy    = 1'b0;
            st_d.ep_last = ent_corner;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o      = st_q.row;
    assign cnt_o      = st_q.cnt;
    assign busy       = st_q.busy;
    assign shift_vld  = st_q.busy && ent.vld;
    assign shift_dir  = ent.dir;
    assign cand_vld   = st_q.busy && ent.vld && ent.cand;
    assign step_done  = walk_end;
    assign ep_out     = walk_end ? ent_corner : st_q.ep_last;
    assign refine_req = st_q.refine;
endmodule

// File: rtl/fss_dir_seq.sv
module fss_dir_seq
    import fss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_go,
    input  logic [1:0] ep_in,
    input  logic [3:0] mp_in,
    output logic       busy,
    output logic       shift_vld,
    output logic [1:0] shift_dir,
    output logic       cand_vld,
    output logic       step_done,
    output logic [1:0] ep_out,
    output logic       refine_req
);
    logic             mp_ok, mp_center;
    logic [2:0]       mp_idx;
    logic [ROW_W-1:0] row;
    logic [CNT_W-1:0] cnt;
    move_t            ent;
    logic [1:0]       ent_corner;

    fss_mp_decode u_dec (
        .mp_i     (mp_in),
        .ok_o     (mp_ok),
        .center_o (mp_center),
        .idx_o    (mp_idx)
    );

    fss_walk_rom u_rom (
        .row_i    (row),
        .cnt_i    (cnt),
        .ent_o    (ent),
        .corner_o (ent_corner)
    );

    fss_step_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_go    (step_go),
        .ep_in      (ep_in),
        .mp_ok      (mp_ok),
        .mp_center  (mp_center),
        .mp_idx     (mp_idx),
        .ent        (ent),
        .ent_corner (ent_corner),
        .row_o      (row),
        .cnt_o      (cnt),
        .busy       (busy),
        .shift_vld  (shift_vld),
        .shift_dir  (shift_dir),
        .cand_vld   (cand_vld),
        .step_done  (step_done),
        .ep_out     (ep_out),
        .refine_req (refine_req)
    );
endmodule

// File: rtl/fss_dir_seq_chk.sv
module fss_dir_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       shift_vld,
    input logic       cand_vld,
    input logic       step_done,
    input logic [1:0] ep_out,
    input logic       refine_req
);
    logic [3:0] moves_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            moves_q <= '0;
        end else if (step_done) begin
            moves_q <= '0;
        end else if (shift_vld) begin
            moves_q <= moves_q + 4'd1;
        end
    end

    // R3
    shift_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld |-> busy && !step_done);

    // R3
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !busy);

    // R3
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_done) |=> busy);

    // R4
    cand_on_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld |-> shift_vld);

    // R4
    min_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> moves_q >= 4'd3);

    // R10
    max_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        moves_q <= 4'd8);

    // R7
    corner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_done |=> (step_done || $stable(ep_out)));

    // R8
    refine_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refine_req |-> !busy && !shift_vld);

    // R8
    refine_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refine_req |=> !refine_req);
endmodule

bind fss_dir_seq fss_dir_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .shift_vld  (shift_vld),
    .cand_vld   (cand_vld),
    .step_done  (step_done),
    .ep_out     (ep_out),
    .refine_req (refine_req)
);

// File: tb/sim_fss_dir_seq.sv
module sim_fss_dir_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_go = 1'b0;
    logic [1:0] ep_in = 2'd0;
    logic [3:0] mp_in = 4'd0;
    logic       busy, shift_vld, cand_vld, step_done, refine_req;
    logic [1:0] shift_dir, ep_out;

    always #10 clk = ~clk;

    fss_dir_seq u0 (
        .clk(clk), .rst_n(rst_n), .step_go(step_go), .ep_in(ep_in), .mp_in(mp_in),
        .busy(busy), .shift_vld(shift_vld), .shift_dir(shift_dir), .cand_vld(cand_vld),
        .step_done(step_done), .ep_out(ep_out), .refine_req(refine_req)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int q_dir[$];
    bit q_cand[$];
    int exp_end;
    int exp_len;
    int act_dir[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ab(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int md(input int ax, input int ay, input int bx, input int by);
        return ab(ax - bx) + ab(ay - by);
    endfunction

    // Behavioural walk model built from R2, R4, R5 and R7.
    function automatic void model(input int ep, input int mp);
        int cx, cy, x, y, ax, ay, bx2, by2, tmp;
        int tx[$];
        int ty[$];
        bit seen[5][5];
        q_dir.delete();
        q_cand.delete();
        foreach (seen[i, j]) seen[i][j] = 1'b0;
        cx = mp % 3 - 1;
        cy = mp / 3 - 1;
        x  = (ep % 2 == 1) ? 1 : -1;
        y  = (ep / 2 == 1) ? 1 : -1;
        if (cx == 0 || cy == 0) begin
            if (cx != 0) begin ax = 2*cx; ay = -1; bx2 = 2*cx; by2 = 1; end
            else         begin ax = -1; ay = 2*cy; bx2 = 1; by2 = 2*cy; end
            if (md(x, y, bx2, by2) < md(x, y, ax, ay)) begin
                tmp = ax; ax = bx2; bx2 = tmp;
                tmp = ay; ay = by2; by2 = tmp;
            end
            exp_len = md(x, y, ax, ay) + 2;
            tx.push_back(ax);  ty.push_back(ay);
            tx.push_back(bx2); ty.push_back(by2);
        end else begin
            if (md(x, y, 2*cx, 0) < md(x, y, 0, 2*cy)) begin
                ax = 2*cx; ay = 0; bx2 = 0; by2 = 2*cy;
            end else begin
                ax = 0; ay = 2*cy; bx2 = 2*cx; by2 = 0;
            end
            exp_len = md(x, y, ax, ay) + 4;
            tx.push_back(ax);   ty.push_back(ay);
            tx.push_back(2*cx); ty.push_back(2*cy);
            tx.push_back(bx2);  ty.push_back(by2);
        end
        foreach (tx[k]) begin
            while (x != tx[k] || y != ty[k]) begin
                if (x != tx[k]) begin
                    q_dir.push_back(x < tx[k] ? 3 : 2);
                    x = (x < tx[k]) ? x + 1 : x - 1;
                end else begin
                    q_dir.push_back(y < ty[k] ? 1 : 0);
                    y = (y < ty[k]) ? y + 1 : y - 1;
                end
                if (ab(x - cx) <= 1 && ab(y - cy) <= 1 && (ab(x) > 1 || ab(y) > 1)
                    && !seen[x+2][y+2]) begin
                    seen[x+2][y+2] = 1'b1;
                    q_cand.push_back(1'b1);
                end else begin
                    q_cand.push_back(1'b0);
                end
            end
        end
        exp_end = ((y - cy) > 0 ? 2 : 0) + ((x - cx) > 0 ? 1 : 0);
    endfunction

    task automatic do_step(input int ep, input int mp, input bit poke);
        string rq;
        rq = poke ? "R9" : "R5";
        model(ep, mp);
        act_dir.delete();
        step_go = 1'b1; ep_in = 2'(ep); mp_in = 4'(mp);
        @(negedge clk);
        step_go = 1'b0;
        foreach (q_dir[i]) begin
            chk(busy == 1'b1, "R3 busy", busy, 1);
            chk(shift_vld == 1'b1, "R3 shift_vld", shift_vld, 1);
            chk(step_done == 1'b0, "R3 early done", step_done, 0);
            chk(int'(shift_dir) == q_dir[i], rq, shift_dir, q_dir[i]);
            chk(cand_vld == q_cand[i], "R4 cand_vld", cand_vld, q_cand[i]);
            act_dir.push_back(int'(shift_dir));
            if (poke && i == 0) begin
                step_go = 1'b1; ep_in = 2'(3 - ep); mp_in = 4'd0;
            end
            @(negedge clk);
            step_go = 1'b0; ep_in = 2'(ep); mp_in = 4'(mp);
        end
        chk(step_done == 1'b1, "R3 done", step_done, 1);
        chk(shift_vld == 1'b0, "R3 shift after walk", shift_vld, 0);
        chk(ep_out == 2'(exp_end), "R7 corner", ep_out, exp_end);
        chk(act_dir.size() == exp_len, "R5 length", act_dir.size(), exp_len);
        @(negedge clk);
        chk(busy == 1'b0, "R3 idle", busy, 0);
        chk(ep_out == 2'(exp_end), "R7 hold", ep_out, exp_end);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int cur;
        int m;
        logic [1:0] keep;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(busy == 0 && shift_vld == 0 && step_done == 0, "R1 in reset", busy, 0);
        chk(refine_req == 0 && cand_vld == 0 && ep_out == 0, "R1 in reset", ep_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && shift_vld == 0 && step_done == 0, "R1 after reset", busy, 0);
        chk(refine_req == 0 && ep_out == 0, "R1 after reset", ep_out, 0);

        // R6: bottom-left corner, best match right
        do_step(2, 5, 1'b0);
        chk(act_dir.size() == 5, "R6 length", act_dir.size(), 5);
        if (act_dir.size() == 5) begin
            chk(act_dir[0] == 3 && act_dir[1] == 3 && act_dir[2] == 3, "R6 rights", act_dir[2], 3);
            chk(act_dir[3] == 0 && act_dir[4] == 0, "R6 ups", act_dir[4], 0);
        end
        chk(ep_out == 2'd1, "R6 corner", ep_out, 1);

        // R10: bottom-left corner, best match top-right
        do_step(2, 2, 1'b0);
        chk(act_dir.size() == 8, "R10 longest", act_dir.size(), 8);

        // R2 R4 R5: every corner with every non-centre position
        for (int e = 0; e < 4; e++) begin
            for (int p = 0; p < 9; p++) begin
                if (p != 4) do_step(e, p, 1'b0);
            end
        end

        // R9: request during a walk is ignored
        do_step(0, 8, 1'b1);
        do_step(3, 1, 1'b1);

        // R7: chained steps, corner fed back
        cur = 0;
        for (int k = 0; k < 12; k++) begin
            m = (k * 5 + 2) % 9;
            if (m == 4) m = 7;
            do_step(cur, m, 1'b0);
            cur = int'(ep_out);
        end

        // R8: centre best match
        keep = ep_out;
        step_go = 1'b1; ep_in = 2'd1; mp_in = 4'd4;
        @(negedge clk);
        step_go = 1'b0;
        chk(refine_req == 1'b1, "R8 refine", refine_req, 1);
        chk(busy == 1'b0 && shift_vld == 1'b0, "R8 no walk", busy, 0);
        @(negedge clk);
        chk(refine_req == 1'b0, "R8 pulse", refine_req, 0);
        chk(busy == 1'b0 && ep_out == keep, "R8 state kept", ep_out, keep);

        // R9: positions above 8 are ignored
        for (int v = 9; v < 16; v++) begin
            step_go = 1'b1; ep_in = 2'd2; mp_in = 4'(v);
            @(negedge clk);
            step_go = 1'b0;
            chk(busy == 0 && shift_vld == 0 && refine_req == 0, "R9 bad position", busy, 0);
            chk(ep_out == keep, "R9 corner kept", ep_out, keep);
        end

        // back-to-back start straight after idle
        do_step(1, 3, 1'b0);
        do_step(int'(ep_out), 6, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule